// File: doc/BRIEF.md
# Cache Lock-Bit Clear Sequencer and Control Register

This block is the 32-bit control and status word that goes with a data cache's line-lock state, plus the sequencer that wipes that state. Software writes a self-clearing start bit. The sequencer then walks the lock-bit array one set index per cycle and pulses a clear strobe for each index. After that it stays busy for a fixed total duration, and then the start bit drops back to zero on its own. An abort request stops a running sweep early and leaves a sticky record that it happened.

The same word holds a few more fields. One is a sticky lock-overflow flag that hardware sets. Another is a policy bit that lets a lock request displace an already-locked line during overflow. There is also a two-bit error-handling selector and a line-length option bit. The policy bit and the selector are exported as outputs for the cache's replacement and error logic. Field positions use bit numbering that counts from the most significant end. A bit numbered n in that scheme sits at register bit 31−n.

Top module: `lkclr_ctrl`

## Requirements
- R1: Writing 1 to the start bit (MSB-numbered 23, register bit 8) while idle raises `busy` on the next cycle. Bit 8 then reads 1 for as long as `busy` is high and reads 0 once the sweep ends. Other field values have no effect on this.
- R2: If there is no abort, `busy` stays high for exactly SWEEP_CYCLES consecutive cycles (default 134).
- R3: In sweep cycle k, counting from 0, `clr_strobe` is high with `clr_index` = k for k < NUM_SETS. `clr_strobe` is low in every other cycle, including all idle cycles.
- R4: While a sweep runs, writing 0 or writing 1 to the start bit neither stops it nor restarts it.
- R5: The overflow flag (MSB-numbered 22, register bit 9) is set one cycle after `ovf_event`. It stays set when software writes 1 to it, and it clears when software writes 0 to it.
- R6: An `abort_req` during a sweep drops `busy` and the start bit on the next cycle. It also sets the abort flag (MSB-numbered 29, register bit 2), which is sticky and is cleared only by a software write of 0. An `abort_req` while idle has no effect.
- R7: If a hardware set and a software write of 0 reach a flag in the same cycle, the flag ends up set.
- R8: The allocate-over-locked bit (MSB-numbered 24, register bit 7) can be read and written, and it drives `alloc_over_locked`.
- R9: The error-action field occupies MSB-numbered bits 25..26, which are register bits 6 (field MSB) and 5. It holds every written value, including the reserved codes 2 and 3, and drives `err_action`. Code 0 selects machine check and code 1 selects correction/auto-invalidate.
- R10: The line-length option (MSB-numbered 28, register bit 3) can be read and written. MSB-numbered bit 27 and all other undefined bits read 0.
- R11: After reset the register reads 0 and `busy` and `clr_strobe` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data |
| ovf_event | input | 1 | Lock overflow event from the cache |
| abort_req | input | 1 | Request to stop a running sweep |
| clr_strobe | output | 1 | Clear the lock bits of set `clr_index` |
| clr_index | output | $clog2(NUM_SETS) | Set index being cleared |
| busy | output | 1 | Sweep in progress |
| alloc_over_locked | output | 1 | Overflow may replace a locked line |
| err_action | output | 2 | Error-handling selector |

## Verification
A step counter that drifts by one shows up directly at the ports. `clr_index` jumps or repeats from one cycle to the next, or `busy` falls one cycle early or late against the fixed sweep length, so the error is visible within a single sweep. A sticky flag with the wrong precedence between hardware set and software clear reads back wrong on the very next read, and the bench provokes exactly that same-cycle collision. If an abort is missed, `busy` is still high one cycle after the request.

// File: rtl/lkclr_pkg.sv
package lkclr_pkg;
  localparam int REG_W = 32;

  // convert MSB-first bit number into an LSB-first register position
  function automatic int msb_pos(input int n);
    return REG_W - 1 - n;
  endfunction

  localparam int OVF_B    = msb_pos(22);
  localparam int START_B  = msb_pos(23);
  localparam int ALLOC_B  = msb_pos(24);
  localparam int ERR_HI_B = msb_pos(25);
  localparam int ERR_LO_B = msb_pos(26);
  localparam int LLEN_B   = msb_pos(28);
  localparam int ABORT_B  = msb_pos(29);

  typedef enum logic [1:0] {
    ERR_MCHECK  = 2'b00,
    ERR_CORRECT = 2'b01,
    ERR_RSVD_A  = 2'b10,
    ERR_RSVD_B  = 2'b11
  } err_mode_e;

  // sticky flag: a hardware set beats a software clear
  function automatic logic sticky_next(input logic q, input logic hw_set,
                                       input logic sw_clr);
    return hw_set | (q & ~sw_clr);
  endfunction

  // a sweep step issues a clear strobe only for real set indices
  function automatic logic strobe_live(input int unsigned step,
                                       input int unsigned nsets);
    return step < nsets;
  endfunction
endpackage

// File: rtl/lkclr_sticky_flag.sv
module lkclr_sticky_flag
  import lkclr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic hw_set,
  input  logic sw_clr,
  output logic q
);
  always_ff @(posedge clk) begin
    if (!rst_n) q <= 1'b0;
    else        q <= sticky_next(q, hw_set, sw_clr);
  end
endmodule

// File: rtl/lkclr_sweep.sv
module lkclr_sweep
  import lkclr_pkg::*;
#(
  parameter int NUM_SETS     = 64,
  parameter int SWEEP_CYCLES = 134,
  localparam int IDX_W = $clog2(NUM_SETS),
  localparam int CNT_W = $clog2(SWEEP_CYCLES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_req,
  input  logic             abort_req,
  output logic             busy,
  output logic             clr_strobe,
  output logic [IDX_W-1:0] clr_index,
  output logic             abort_evt,
  output logic             done_evt
);
  localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(SWEEP_CYCLES - 1);

  logic [CNT_W-1:0] step_q;

  assign abort_evt  = busy & abort_req;
  assign done_evt   = busy & ~abort_req & (step_q == LAST_STEP);
  assign clr_strobe = busy & strobe_live(32'(step_q), NUM_SETS);
  assign clr_index  = step_q[IDX_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      step_q <= '0;
    end else if (busy) begin
      if (abort_evt || done_evt) begin
        busy   <= 1'b0;
        step_q <= '0;
      end else begin
        step_q <= step_q + 1'b1;
      end
    end else if (start_req) begin
      busy   <= 1'b1;
      step_q <= '0;
    end
  end
endmodule

// File: rtl/lkclr_ctrl.sv
module lkclr_ctrl
  import lkclr_pkg::*;
#(
  parameter int NUM_SETS     = 64,
  parameter int SWEEP_CYCLES = 134,
  localparam int IDX_W = $clog2(NUM_SETS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  input  logic             ovf_event,
  input  logic             abort_req,
  output logic             clr_strobe,
  output logic [IDX_W-1:0] clr_index,
  output logic             busy,
  output logic             alloc_over_locked,
  output logic [1:0]       err_action
);
  localparam int N_FLAGS = 2;
  localparam int FLAG_OVF = 0;
  localparam int FLAG_ABT = 1;
  localparam int FLAG_POS [N_FLAGS] = '{OVF_B, ABORT_B};

  // named internal events for the checker
  logic start_req;
  logic abort_evt;
  logic done_evt;

  logic [N_FLAGS-1:0] flag_set, flag_clr, flag_q;
  logic               alloc_q, llen_q;
  err_mode_e          err_q;

  assign start_req = reg_we & reg_wdata[START_B] & ~busy;

  lkclr_sweep #(.NUM_SETS(NUM_SETS), .SWEEP_CYCLES(SWEEP_CYCLES)) sweep_i (
    .clk(clk), .rst_n(rst_n), .start_req(start_req), .abort_req(abort_req),
    .busy(busy), .clr_strobe(clr_strobe), .clr_index(clr_index),
    .abort_evt(abort_evt), .done_evt(done_evt)
  );

  assign flag_set[FLAG_OVF] = ovf_event;
  assign flag_set[FLAG_ABT] = abort_evt;

  for (genvar g = 0; g < N_FLAGS; g++) begin : g_flag
    assign flag_clr[g] = reg_we & ~reg_wdata[FLAG_POS[g]];
    lkclr_sticky_flag flag_i (
      .clk(clk), .rst_n(rst_n), .hw_set(flag_set[g]),
      .sw_clr(flag_clr[g]), .q(flag_q[g])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      alloc_q <= 1'b0;
      llen_q  <= 1'b0;
      err_q   <= ERR_MCHECK;
    end else if (reg_we) begin
      alloc_q <= reg_wdata[ALLOC_B];
      llen_q  <= reg_wdata[LLEN_B];
      err_q   <= err_mode_e'({reg_wdata[ERR_HI_B], reg_wdata[ERR_LO_B]});
    end
  end

  assign alloc_over_locked = alloc_q;
  assign err_action        = err_q;

  always_comb begin
    reg_rdata           = '0;
    reg_rdata[OVF_B]    = flag_q[FLAG_OVF];
    reg_rdata[START_B]  = busy;
    reg_rdata[ALLOC_B]  = alloc_q;
    reg_rdata[ERR_HI_B] = err_q[1];
    reg_rdata[ERR_LO_B] = err_q[0];
    reg_rdata[LLEN_B]   = llen_q;
    reg_rdata[ABORT_B]  = flag_q[FLAG_ABT];
  end
endmodule

// File: rtl/lkclr_chk.sv
module lkclr_chk
  import lkclr_pkg::*;
#(
  parameter int NUM_SETS     = 64,
  parameter int SWEEP_CYCLES = 134,
  localparam int IDX_W = $clog2(NUM_SETS),
  localparam int LEN_W = $clog2(SWEEP_CYCLES + 2)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_we,
  input logic [31:0]      reg_wdata,
  input logic [31:0]      reg_rdata,
  input logic             ovf_event,
  input logic             abort_req,
  input logic             clr_strobe,
  input logic [IDX_W-1:0] clr_index,
  input logic             busy,
  input logic             done_evt
);
  logic [LEN_W-1:0] run_len;
  always_ff @(posedge clk) begin
    if (!rst_n)    run_len <= '0;
    else if (busy) run_len <= run_len + 1'b1;
    else           run_len <= '0;
  end

  AST_START_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && reg_we && reg_wdata[START_B]) |=> (busy && reg_rdata[START_B])); // R1
  AST_SWEEP_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && !$past(abort_req)) |-> (run_len == LEN_W'(SWEEP_CYCLES))); // R2
  AST_STROBE_IN_SWEEP: assert property (@(posedge clk) disable iff (!rst_n)
    clr_strobe |-> busy); // R3
  AST_INDEX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_strobe && $past(clr_strobe)) |-> (clr_index == $past(clr_index) + 1'b1)); // R3
  AST_NO_EARLY_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !abort_req && !done_evt) |=> busy); // R4
  AST_OVF_SET: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_event |=> reg_rdata[OVF_B]); // R5
  AST_ABORT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && abort_req) |=> (!busy && !reg_rdata[START_B] && reg_rdata[ABORT_B])); // R6
endmodule

bind lkclr_ctrl lkclr_chk #(.NUM_SETS(NUM_SETS), .SWEEP_CYCLES(SWEEP_CYCLES)) chk_i (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_wdata(reg_wdata),
  .reg_rdata(reg_rdata), .ovf_event(ovf_event), .abort_req(abort_req),
  .clr_strobe(clr_strobe), .clr_index(clr_index), .busy(busy),
  .done_evt(done_evt)
);

// File: tb/lkclr_ctrl_tb_top.sv
module lkclr_ctrl_tb_top;
  localparam int NS    = 64;
  localparam int SWEEP = 134;
  localparam int IW    = $clog2(NS);
  localparam logic [31:0] START = 32'h100, OVF = 32'h200, ABT = 32'h4;
  localparam int NV = 6;
  localparam logic [31:0] VW [NV] = '{32'h0000_00E8, 32'h0000_0040, 32'h0000_0020,
                                      32'hFFFF_FEFF, 32'h0000_0018, 32'h0000_0060};
  localparam logic [31:0] VE [NV] = '{32'h0000_00E8, 32'h0000_0040, 32'h0000_0020,
                                      32'h0000_00E8, 32'h0000_0008, 32'h0000_0060};

  logic clk = 1'b0, rst_n = 1'b0, reg_we = 1'b0, ovf_event = 1'b0, abort_req = 1'b0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic clr_strobe, busy, alloc_over_locked;
  logic [IW-1:0] clr_index;
  logic [1:0] err_action;
  int n_chk = 0, n_err = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  lkclr_ctrl #(.NUM_SETS(NS), .SWEEP_CYCLES(SWEEP)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .ovf_event(ovf_event), .abort_req(abort_req),
    .clr_strobe(clr_strobe), .clr_index(clr_index), .busy(busy),
    .alloc_over_locked(alloc_over_locked), .err_action(err_action)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] d);
    reg_we = 1'b1; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0; reg_wdata = '0;
  endtask

  // sweep already launched; called at the first busy negedge
  task automatic sweep_run(input int w0_at, input int w1_at, input int ab_at);
    for (int i = 0; i < SWEEP; i++) begin
      chk("R2 busy", 32'(busy), 32'd1);
      chk("R1 start bit reads 1", 32'(reg_rdata[8]), 32'd1);
      chk("R3 strobe", 32'(clr_strobe), 32'(i < NS));
      if (i < NS) chk("R3 index", 32'(clr_index), 32'(i));
      if (i == ab_at) begin
        abort_req = 1'b1; reg_we = 1'b1; reg_wdata = 32'h0; // R7 same-cycle clear
        @(negedge clk);
        abort_req = 1'b0; reg_we = 1'b0;
        chk("R6 busy drops", 32'(busy), 32'd0);
        chk("R6 start bit 0", 32'(reg_rdata[8]), 32'd0);
        chk("R7 abort flag wins", 32'(reg_rdata[2]), 32'd1);
        return;
      end
      if (i == w0_at) begin reg_we = 1'b1; reg_wdata = 32'h0; end
      if (i == w1_at) begin reg_we = 1'b1; reg_wdata = START; end
      @(negedge clk);
      reg_we = 1'b0;
    end
    chk("R2 busy ends", 32'(busy), 32'd0);
    chk("R1 start bit clears", 32'(reg_rdata[8]), 32'd0);
    chk("R3 no strobe idle", 32'(clr_strobe), 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R11 rdata", reg_rdata, 32'h0);
    chk("R11 busy", 32'(busy), 32'd0);
    chk("R11 strobe", 32'(clr_strobe), 32'd0);

    for (int v = 0; v < NV; v++) begin // R8 R9 R10
      wr(VW[v]);
      chk("R10 readback", reg_rdata, VE[v]);
      chk("R8 alloc out", 32'(alloc_over_locked), 32'(VE[v][7]));
      chk("R9 err out", 32'(err_action), 32'(VE[v][6:5]));
    end

    // R1 sweep with other fields set, and R4 writes of 0 and 1 mid-sweep
    wr(START | 32'hE8);
    sweep_run(10, 70, -1);
    chk("R1 other fields kept", reg_rdata, 32'h0);

    wr(START | 32'hE8);
    sweep_run(-1, -1, -1);
    chk("R1 fields after sweep", reg_rdata, 32'hE8);

    // R5 overflow flag
    ovf_event = 1'b1; @(negedge clk); ovf_event = 1'b0;
    chk("R5 ovf set", 32'(reg_rdata[9]), 32'd1);
    wr(32'hFFFF_FEFF);
    chk("R5 ovf write 1 keeps", 32'(reg_rdata[9]), 32'd1);
    wr(32'h0);
    chk("R5 ovf write 0 clears", 32'(reg_rdata[9]), 32'd0);
    ovf_event = 1'b1; wr(32'h0); ovf_event = 1'b0;
    chk("R7 ovf set beats clear", 32'(reg_rdata[9]), 32'd1);
    wr(32'h0);

    // R6 abort while idle
    abort_req = 1'b1; @(negedge clk); abort_req = 1'b0;
    chk("R6 idle abort no flag", reg_rdata, 32'h0);
    chk("R6 idle abort no busy", 32'(busy), 32'd0);

    // R6 abort mid-sweep, sticky flag
    wr(START);
    sweep_run(-1, -1, 30);
    repeat (3) @(negedge clk);
    chk("R6 stays idle", 32'(busy), 32'd0);
    wr(OVF | ABT);
    chk("R6 abort flag sticky", 32'(reg_rdata[2]), 32'd1);
    wr(32'h0);
    chk("R6 abort flag cleared", 32'(reg_rdata[2]), 32'd0);

    // R6 abort in the final sweep cycle
    wr(START);
    sweep_run(-1, -1, SWEEP - 1);
    wr(32'h0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule